// File: doc/BRIEF.md
# DMA Cycle Timing Generator

This block produces the read/write strobe for single-word and multiword DMA transfers on an IDE data bus. A transfer is started with a one-cycle start request that carries a timing type and a word count. The block then emits one strobe cycle per word. Each strobe cycle has an active phase, with the strobe high, and a recovery phase, with the strobe low. Both phases last a whole number of reference clock ticks, derived from fixed nanosecond figures and the clock period parameter.

A new strobe cycle begins only when the drive's DMA request is high. When the last word's recovery phase ends, the block pulses done and drops busy. A start request that arrives while a transfer is running is dropped and reported with an error pulse, so a second channel cannot take over the engine during a transfer.

A separate combinational selector turns a requested ATA transfer mode and the drive's reported minimum cycle time into a timing type. Software can use this type for the next start request.

Top module: `dma_strobe_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, strobe, busy, done and start_err are all low.
- R2: Timing type codes are 0 for A, 1 for B, 2 for C and 3 for D. The active phases last 250, 187, 125 and 62 ns respectively. Every strobe high pulse lasts exactly ceil(active_ns*1000/CLK_PS) clock cycles for the type given with the accepted start.
- R3: While DMA request stays high, the low gap between consecutive strobe pulses of one transfer is exactly ceil(recovery_ns*1000/CLK_PS) cycles. The recovery times are 312 ns for A, 250 ns for B, 125 ns for C and 125 ns for D.
- R4: An accepted start with a nonzero word count N gives exactly N strobe pulses. Done is a single-cycle pulse. It rises, and busy falls, in the same cycle, which comes a full recovery time after the last strobe falls.
- R5: A strobe pulse begins only on a clock edge at which DMA request is high. While it is low between words, the strobe stays low and the transfer waits.
- R6: A start request made while busy is high changes neither the running transfer nor its word count. It raises start_err for exactly the next cycle.
- R7: A start request with word count 0 while idle produces no strobe and keeps busy low. It pulses done in the next cycle.
- R8: The mode input is {multiword, number[1:0]}. The requested cycle time is 250 ns for a multiword number of 1 or more, and 480 ns otherwise. Only in the first case is it raised to the drive-reported minimum cycle time when that value is larger.
- R9: The selector outputs the fastest type whose total cycle time is at least the requested time. The cycle times are 187 ns for D, 250 ns for C, 437 ns for B and 562 ns for A. When no type is long enough, it outputs A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle transfer start request |
| timing_type | input | 2 | Timing type for the transfer (0=A, 1=B, 2=C, 3=D) |
| word_count | input | WCW | Number of strobe cycles to run |
| dmarq | input | 1 | Drive DMA request; gates the start of each cycle |
| strobe | output | 1 | Read/write strobe, high during active phase |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at end of last recovery |
| start_err | output | 1 | One-cycle pulse when a start hits a busy engine |
| xfer_mode | input | 3 | Requested ATA mode {multiword, number} for the selector |
| drive_min_ns | input | 16 | Drive-reported minimum DMA cycle time in ns |
| sel_type | output | 2 | Timing type chosen by the selector |

## Verification
A wrong phase counter shows up at the first strobe as a pulse width or gap that is off by some cycles. A bad latched timing type shows the same way, since it selects the wrong tick counts from the start of the transfer. A corrupt word counter shows up only at the end of the transfer: the strobe pulses come out in the wrong number, or done arrives early or late relative to the last falling edge. A fault in the DMA-request gate or the busy guard shows within a cycle, as a strobe rising with the request low, or as a missing or extra error pulse. Selector faults are visible on the same cycle as the mode input changes.

// File: rtl/dma_timing_pkg.sv
package dma_timing_pkg;

    typedef enum logic [1:0] {
        TT_A = 2'd0,
        TT_B = 2'd1,
        TT_C = 2'd2,
        TT_D = 2'd3
    } tt_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_ACT  = 2'd2,
        ST_REC  = 2'd3
    } st_e;

    function automatic int unsigned act_ns(tt_e t);
        case (t)
            TT_A:    return 250;
            TT_B:    return 187;
            TT_C:    return 125;
            default: return 62;
        endcase
    endfunction

    function automatic int unsigned rec_ns(tt_e t);
        case (t)
            TT_A:    return 312;
            TT_B:    return 250;
            default: return 125;
        endcase
    endfunction

    function automatic int unsigned cycle_ns(tt_e t);
        return act_ns(t) + rec_ns(t);
    endfunction

    function automatic int unsigned ns_to_ticks(int unsigned ns, int unsigned clk_ps);
        return (ns * 1000 + clk_ps - 1) / clk_ps;
    endfunction

endpackage

// File: rtl/dma_mode_sel.sv
module dma_mode_sel
    import dma_timing_pkg::*;
(
    input  logic [2:0]  xfer_mode,
    input  logic [15:0] drive_min_ns,
    output tt_e         sel_type
);
    logic        fast_mw;
    logic [31:0] req_ns;

    always_comb begin
        fast_mw = xfer_mode[2] && (xfer_mode[1:0] != 2'd0);
        if (fast_mw) begin
            req_ns = 32'd250;
            if ({16'd0, drive_min_ns} > req_ns)
                req_ns = {16'd0, drive_min_ns};
        end else begin
            req_ns = 32'd480;
        end

        if (req_ns <= cycle_ns(TT_D))      sel_type = TT_D;
        else if (req_ns <= cycle_ns(TT_C)) sel_type = TT_C;
        else if (req_ns <= cycle_ns(TT_B)) sel_type = TT_B;
        else                               sel_type = TT_A;
    end
endmodule

// File: rtl/dma_tick_table.sv
module dma_tick_table
    import dma_timing_pkg::*;
#(
    parameter int unsigned CLK_PS = 4000,
    parameter int unsigned CNT_W  = 8
) (
    input  tt_e              ttype,
    output logic [CNT_W-1:0] act_ticks,
    output logic [CNT_W-1:0] rec_ticks
);
    logic [CNT_W-1:0] act_lut [4];
    logic [CNT_W-1:0] rec_lut [4];

    for (genvar i = 0; i < 4; i++) begin : g_type
        localparam tt_e T = tt_e'(i);
        assign act_lut[i] = CNT_W'(ns_to_ticks(act_ns(T), CLK_PS));
        assign rec_lut[i] = CNT_W'(ns_to_ticks(rec_ns(T), CLK_PS));
    end

    assign act_ticks = act_lut[ttype];
    assign rec_ticks = rec_lut[ttype];
endmodule

// File: rtl/dma_strobe_fsm.sv
module dma_strobe_fsm
    import dma_timing_pkg::*;
#(
    parameter int unsigned WCW   = 8,
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  tt_e              type_in,
    input  logic [WCW-1:0]   word_count,
    input  logic             dmarq,
    input  logic [CNT_W-1:0] act_ticks,
    input  logic [CNT_W-1:0] rec_ticks,
    output tt_e              cur_type,
    output logic             strobe,
    output logic             busy,
    output logic             done,
    output logic             start_err
);
    typedef struct packed {
        st_e              state;
        logic [CNT_W-1:0] cnt;
        logic [WCW-1:0]   words;
        tt_e              ttype;
        logic             done;
        logic             err;
    } fsm_t;

    fsm_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.err  = 1'b0;
        case (s_q.state)
            ST_IDLE: begin
                if (start) begin
                    if (word_count == '0) begin
                        s_d.done = 1'b1;
                    end else begin
                        s_d.state = ST_WAIT;
                        s_d.words = word_count;
                        s_d.ttype = type_in;
                    end
                end
            end
            ST_WAIT: begin
                if (dmarq) begin
                    s_d.state = ST_ACT;
                    s_d.cnt   = act_ticks - 1'b1;
                end
            end
            ST_ACT: begin
                if (s_q.cnt == '0) begin
                    s_d.state = ST_REC;
                    s_d.cnt   = rec_ticks - 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end else if (s_q.words == WCW'(1)) begin
                    s_d.state = ST_IDLE;
                    s_d.words = '0;
                    s_d.done  = 1'b1;
                end else begin
                    s_d.words = s_q.words - 1'b1;
                    if (dmarq) begin
                        s_d.state = ST_ACT;
                        s_d.cnt   = act_ticks - 1'b1;
                    end else begin
                        s_d.state = ST_WAIT;
                    end
                end
            end
        endcase
        if (start && s_q.state != ST_IDLE)
            s_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{state: ST_IDLE, cnt: '0, words: '0, ttype: TT_A,
                     done: 1'b0, err: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign cur_type  = s_q.ttype;
    assign strobe    = (s_q.state == ST_ACT);
    assign busy      = (s_q.state != ST_IDLE);
    assign done      = s_q.done;
    assign start_err = s_q.err;
endmodule

// File: rtl/dma_strobe_gen.sv
module dma_strobe_gen
    import dma_timing_pkg::*;
#(
    parameter int unsigned CLK_PS = 4000,
    parameter int unsigned WCW    = 8,
    parameter int unsigned CNT_W  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [1:0]     timing_type,
    input  logic [WCW-1:0] word_count,
    input  logic           dmarq,
    output logic           strobe,
    output logic           busy,
    output logic           done,
    output logic           start_err,
    input  logic [2:0]     xfer_mode,
    input  logic [15:0]    drive_min_ns,
    output logic [1:0]     sel_type
);
    tt_e              cur_type;
    tt_e              sel_tt;
    logic [CNT_W-1:0] act_ticks;
    logic [CNT_W-1:0] rec_ticks;

    dma_mode_sel u_sel (
        .xfer_mode    (xfer_mode),
        .drive_min_ns (drive_min_ns),
        .sel_type     (sel_tt)
    );

    dma_tick_table #(.CLK_PS(CLK_PS), .CNT_W(CNT_W)) u_tab (
        .ttype     (cur_type),
        .act_ticks (act_ticks),
        .rec_ticks (rec_ticks)
    );

    dma_strobe_fsm #(.WCW(WCW), .CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .type_in    (tt_e'(timing_type)),
        .word_count (word_count),
        .dmarq      (dmarq),
        .act_ticks  (act_ticks),
        .rec_ticks  (rec_ticks),
        .cur_type   (cur_type),
        .strobe     (strobe),
        .busy       (busy),
        .done       (done),
        .start_err  (start_err)
    );

    assign sel_type = sel_tt;
endmodule

// File: rtl/dma_strobe_gen_chk.sv
module dma_strobe_gen_chk
    import dma_timing_pkg::*;
#(
    parameter int unsigned CLK_PS = 4000,
    parameter int unsigned WCW    = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic [1:0]     timing_type,
    input logic [WCW-1:0] word_count,
    input logic           dmarq,
    input logic           strobe,
    input logic           busy,
    input logic           done,
    input logic           start_err,
    input logic [2:0]     xfer_mode,
    input logic [15:0]    drive_min_ns,
    input logic [1:0]     sel_type
);
    tt_e         lat_tt;
    int unsigned run_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_tt  <= TT_A;
            run_len <= 0;
        end else begin
            if (start && !busy) lat_tt <= tt_e'(timing_type);
            run_len <= strobe ? run_len + 1 : 0;
        end
    end

    // R2: every high pulse has the active width of the accepted type
    p_act_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe) |-> run_len == ns_to_ticks(act_ns(lat_tt), CLK_PS));

    // R4: done coincides with the end of busy
    p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R5: a pulse begins only with the request high
    p_rise_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe) |-> $past(dmarq));

    // R5: strobe only during a transfer
    p_strobe_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> busy);

    // R6: error pulse only after a start that hit a busy engine
    p_err_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_err |-> ($past(start) && $past(busy)));

    // R8: single-word modes always resolve to the slowest type
    p_sw_slow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_mode[2] |-> sel_type == 2'd0);

    // R9: fast multiword modes with a small drive minimum resolve to type C
    p_mw_fast_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_mode[2] && xfer_mode[1:0] != 2'd0 && drive_min_ns <= 16'd250)
        |-> sel_type == 2'd2);
endmodule

bind dma_strobe_gen dma_strobe_gen_chk #(.CLK_PS(CLK_PS), .WCW(WCW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .timing_type  (timing_type),
    .word_count   (word_count),
    .dmarq        (dmarq),
    .strobe       (strobe),
    .busy         (busy),
    .done         (done),
    .start_err    (start_err),
    .xfer_mode    (xfer_mode),
    .drive_min_ns (drive_min_ns),
    .sel_type     (sel_type)
);

// File: tb/dma_strobe_gen_tb.sv
`timescale 1ns/1ps
module dma_strobe_gen_tb;
    localparam int CLK_PS = 4000;
    localparam int WCW    = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [1:0]     timing_type = 2'd0;
    logic [WCW-1:0] word_count = '0;
    logic           dmarq = 1'b0;
    logic           strobe, busy, done, start_err;
    logic [2:0]     xfer_mode = 3'd0;
    logic [15:0]    drive_min_ns = 16'd0;
    logic [1:0]     sel_type;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dma_strobe_gen #(.CLK_PS(CLK_PS), .WCW(WCW), .CNT_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .timing_type(timing_type),
        .word_count(word_count), .dmarq(dmarq), .strobe(strobe), .busy(busy),
        .done(done), .start_err(start_err), .xfer_mode(xfer_mode),
        .drive_min_ns(drive_min_ns), .sel_type(sel_type)
    );

    function automatic int ceil_ticks(int ns);
        return (ns * 1000 + CLK_PS - 1) / CLK_PS;
    endfunction

    function automatic int exp_act(int t);
        case (t)
            0: return ceil_ticks(250);
            1: return ceil_ticks(187);
            2: return ceil_ticks(125);
            default: return ceil_ticks(62);
        endcase
    endfunction

    function automatic int exp_rec(int t);
        case (t)
            0: return ceil_ticks(312);
            1: return ceil_ticks(250);
            default: return ceil_ticks(125);
        endcase
    endfunction

    function automatic int exp_sel(int mode, int dmin);
        int req;
        if (mode[2] && mode[1:0] != 0) begin
            req = 250;
            if (dmin > req) req = dmin;
        end else begin
            req = 480;
        end
        if (req <= 187) return 3;
        if (req <= 250) return 2;
        if (req <= 437) return 1;
        return 0;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_xfer(input int t, input int n, input bit gaps, input bit poke);
        int hi = 0, lo = 0, pulses = 0, cyc = 0;
        bit prev = 1'b0, seen = 1'b0, last_dq = 1'b1, poked = 1'b0, err_due = 1'b0;
        @(negedge clk);
        start = 1'b1; timing_type = 2'(t); word_count = WCW'(n); dmarq = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!seen && cyc < 20000) begin
            cyc++;
            if (err_due) begin
                chk(start_err == 1'b1, "R6 start_err", int'(start_err), 1);
                err_due = 1'b0;
                start = 1'b0;
            end
            if (strobe) begin
                if (!prev) begin
                    pulses++;
                    chk(last_dq == 1'b1, "R5 rise needs dmarq", int'(last_dq), 1);
                    if (pulses > 1 && !gaps) chk(lo == exp_rec(t), "R3 gap", lo, exp_rec(t));
                    lo = 0;
                end
                hi++;
            end else begin
                if (prev) begin
                    chk(hi == exp_act(t), "R2 width", hi, exp_act(t));
                    hi = 0;
                end
                lo++;
            end
            prev = strobe;
            if (done) begin
                seen = 1'b1;
                chk(pulses == n, "R4 pulse count", pulses, n);
                chk(busy == 1'b0, "R4 busy at done", int'(busy), 0);
                chk(lo == exp_rec(t) + 1, "R4 done timing", lo, exp_rec(t) + 1);
            end
            if (poke && !poked && pulses == 1 && hi == 2) begin
                start = 1'b1; word_count = WCW'(5); timing_type = 2'((t + 1) % 4);
                poked = 1'b1; err_due = 1'b1;
            end
            if (gaps) dmarq = ($urandom % 3) != 0;
            last_dq = dmarq;
            if (!seen) @(negedge clk);
        end
        if (!seen) chk(1'b0, "R4 done never seen", 0, 1);
        @(negedge clk);
        chk(done == 1'b0, "R4 done one cycle", int'(done), 0);
        dmarq = 1'b1;
    endtask

    initial begin
        int cyc = 0;
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000 && !finished) begin
                bad++; total++;
                $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
                finished = 1'b1;
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk({strobe, busy, done, start_err} == 4'b0, "R1 in reset",
            int'({strobe, busy, done, start_err}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({strobe, busy, done, start_err} == 4'b0, "R1 after reset",
            int'({strobe, busy, done, start_err}), 0);

        // R7: zero word count
        start = 1'b1; word_count = '0; timing_type = 2'd2;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1, "R7 done", int'(done), 1);
        chk(busy == 1'b0 && strobe == 1'b0, "R7 idle", int'({busy, strobe}), 0);
        @(negedge clk);
        chk(done == 1'b0 && strobe == 1'b0, "R7 quiet", int'({done, strobe}), 0);

        for (int t = 0; t < 4; t++) run_xfer(t, 3, 1'b0, 1'b0);
        run_xfer(2, 4, 1'b0, 1'b1);
        run_xfer(0, 2, 1'b1, 1'b1);
        for (int i = 0; i < 6; i++)
            run_xfer(int'($urandom % 4), 1 + int'($urandom % 6), bit'($urandom % 2), 1'b0);

        // R8/R9 directed selector corners
        begin
            int md [7] = '{4, 5, 6, 6, 0, 2, 7};
            int dm [7] = '{100, 200, 300, 600, 900, 50, 437};
            for (int i = 0; i < 7; i++) begin
                @(negedge clk);
                xfer_mode = 3'(md[i]); drive_min_ns = 16'(dm[i]);
                #1;
                chk(int'(sel_type) == exp_sel(md[i], dm[i]), "R8 R9 selector",
                    int'(sel_type), exp_sel(md[i], dm[i]));
            end
        end
        for (int i = 0; i < 40; i++) begin
            int m = int'($urandom % 8);
            int d = int'($urandom % 700);
            @(negedge clk);
            xfer_mode = 3'(m); drive_min_ns = 16'(d);
            #1;
            chk(int'(sel_type) == exp_sel(m, d), "R9 selector random",
                int'(sel_type), exp_sel(m, d));
        end

        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule